// File: doc/BRIEF.md
# Multi-mode interval counter channel

This block is a single 16-bit timer channel. A loaded count N sets the length of a timing interval. Time moves forward one tick on each clock cycle where the tick enable input is high and the gate lets counting run. Six counting behaviours can be chosen: a terminal-count flag, a retriggerable one-shot, a periodic rate pulse, a square wave, and two strobe modes. A strobe can be started either by the load itself or by a gate edge.

A register front end loads the channel by presenting a 16-bit value, a mode code and a one-cycle load strobe. It reads the live count and the output level back on `count_out` and `out_pin`. The gate input is synchronised inside the block through two flops, and its edges are detected on the synchronised copy.

Top module: `interval_channel`

## Requirements
- R1: After reset and before the first load, `out_pin` is 0, `count_out` is 0, and ticks and gate activity change neither.
- R2: A load value of 0 is taken as N = 65536. In a terminal-count mode, `count_out` reads 0 right after the load and 0xFFFF after one tick, and `out_pin` first rises on tick 65536.
- R3: Mode code 0 (terminal-count flag): `out_pin` is 0 after a load. It becomes 1 once the elapsed ticks since the load reach N, and it stays 1 until the next load.
- R4: Mode code 1 (retriggerable one-shot): `out_pin` is 0 while the elapsed ticks are below N and 1 afterwards. A rising edge on the gate sets the elapsed ticks back to 0.
- R5: Mode code 2 (rate generator): `out_pin` is 1 exactly when the elapsed ticks d are nonzero and d mod N = 0. The count reads N - (d mod N), modulo 65536, so it reloads every N ticks.
- R6: Mode code 3 (square wave): with p = d mod N, `out_pin` is 1 when p < (N+1)/2, using integer division, and 0 otherwise. The count reads N - ((2p) mod N), modulo 65536, so it steps down by two per tick.
- R7: Mode codes 4 and 5 (strobes): `out_pin` is 1 only while the elapsed ticks equal N. This gives one pulse lasting one tick, and it does not repeat.
- R8: The gate is taken through two synchronising flops. With the synchronised gate low, counting stops in modes 0, 2, 3 and 4. In modes 1 and 5 the gate level does not matter. A rising edge of the synchronised gate in modes 1, 2, 3 and 5 sets the elapsed ticks to 0. A load in the same cycle takes priority.
- R9: Elapsed ticks advance only in cycles where `tick_en` is 1. In any other cycle without a load or a restart, `count_out` and `out_pin` hold.
- R10: In modes 0, 1, 4 and 5, `count_out` equals N minus the elapsed ticks, modulo 65536, and it keeps wrapping after the terminal count.
- R11: The mode code is read from `mode_sel` at load. Codes 6 and 7 behave as codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-advance enable |
| gate | input | 1 | Asynchronous gate input |
| load | input | 1 | One-cycle load strobe |
| mode_sel | input | 3 | Mode code, sampled on load |
| load_val | input | 16 | Count value, sampled on load (0 means 65536) |
| count_out | output | 16 | Current readable count |
| out_pin | output | 1 | Channel output level |

## Verification
The bench checks the wrap at N = 65536 across the whole interval. A design that kept zero as zero would raise the output at once. The bench also runs square waves with odd N (5, 7) and with N = 1 and 2. If the high phase were rounded the wrong way, the high phase and the count sequence would each be off by one tick. It applies gate edges in the middle of an interval in the one-shot, rate and square modes, and gate-low stalls in modes 0 and 4. A design that confused restarting with pausing would drift from the model from that point on. Finally, it runs strobe modes well past the terminal count to catch a repeated pulse, and loads codes 6 and 7 to catch modes that were not aliased.

// File: rtl/interval_channel.sv
module interval_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         gate,
  input  logic         load,
  input  logic [2:0]   mode_sel,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count_out,
  output logic         out_pin
);
  localparam int CW = W + 1;
  localparam logic [CW-1:0] FULL = CW'(1) << W;

  logic          armed, wrapped_q, reached_q, hit_q, g1, g2;
  logic [2:0]    mode_q;
  logic [CW-1:0] n_q, e_q;

  wire rise     = g1 & ~g2;
  wire periodic = (mode_q == 3'd2) || (mode_q == 3'd3);
  wire retrig   = (mode_q != 3'd0) && (mode_q != 3'd4);
  wire gated    = (mode_q != 3'd1) && (mode_q != 3'd5);
  wire run      = armed & tick_en & (~gated | g1);
  wire restart  = armed & rise & retrig;

  wire [CW-1:0] e_inc  = e_q + 1'b1;
  wire          at_end = (e_inc == n_q);
  wire [2:0]    mode_m = (mode_sel > 3'd5) ? mode_sel - 3'd4 : mode_sel;

  wire [CW:0]   twice  = {e_q, 1'b0};
  wire [CW:0]   folded = (twice >= {1'b0, n_q}) ? twice - {1'b0, n_q} : twice;
  wire [CW-1:0] half   = (n_q + 1'b1) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0; mode_q <= '0; n_q <= '0; e_q <= '0;
      wrapped_q <= 1'b0; reached_q <= 1'b0; hit_q <= 1'b0;
      g1 <= 1'b0; g2 <= 1'b0;
    end else begin
      g1 <= gate;
      g2 <= g1;
      if (load) begin
        armed     <= 1'b1;
        mode_q    <= mode_m;
        n_q       <= (load_val == '0) ? FULL : {1'b0, load_val};
        e_q       <= '0;
        wrapped_q <= 1'b0; reached_q <= 1'b0; hit_q <= 1'b0;
      end else if (restart) begin
        e_q       <= '0;
        wrapped_q <= 1'b0; reached_q <= 1'b0; hit_q <= 1'b0;
      end else if (run) begin
        if (periodic) begin
          e_q <= at_end ? '0 : e_inc;
          if (at_end) wrapped_q <= 1'b1;
        end else begin
          e_q       <= e_inc;
          hit_q     <= at_end & ~reached_q;
          reached_q <= reached_q | at_end;
        end
      end
    end
  end

  logic [CW-1:0] cnt_full;
  always_comb begin
    if (!armed)               cnt_full = '0;
    else if (mode_q == 3'd3)  cnt_full = n_q - folded[CW-1:0];
    else                      cnt_full = n_q - e_q;
  end
  assign count_out = cnt_full[W-1:0];

  always_comb begin
    if (!armed) out_pin = 1'b0;
    else case (mode_q)
      3'd0, 3'd1: out_pin = reached_q;
      3'd2:       out_pin = wrapped_q && (e_q == '0);
      3'd3:       out_pin = (e_q < half);
      default:    out_pin = hit_q;
    endcase
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> (!out_pin && count_out == '0));
  a_r2_zero_is_full: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> (n_q == FULL && count_out == '0));
  a_r3_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode_q == 3'd0 && out_pin && !load) |=> out_pin);
  a_r7_one_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode_q >= 3'd4 && out_pin && run && !load && !restart) |=> !out_pin);
  a_r9_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load && !restart) |=> ($stable(count_out) && $stable(out_pin)));
  a_r11_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mode_q <= 3'd5));
endmodule

// File: tb/sim_interval_channel.sv
module sim_interval_channel;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, gate = 1'b1, load = 1'b0;
  logic [2:0]  mode_sel = '0;
  logic [15:0] load_val = '0;
  logic [15:0] count_out;
  logic        out_pin;

  always #5 clk = ~clk;

  interval_channel u0 (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load(load), .mode_sel(mode_sel), .load_val(load_val),
    .count_out(count_out), .out_pin(out_pin));

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference
  bit m_armed = 0, m_g1 = 0, m_g2 = 0;
  int m_mode = 0;
  longint m_n = 0, m_d = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_armed = 0; m_mode = 0; m_n = 0; m_d = 0; m_g1 = 0; m_g2 = 0;
    end else begin
      bit gated_mode, retrig_mode;
      gated_mode  = !(m_mode == 1 || m_mode == 5);
      retrig_mode = !(m_mode == 0 || m_mode == 4);
      if (load) begin
        m_armed = 1; m_d = 0;
        m_n = (load_val == 0) ? 65536 : longint'(load_val);
        m_mode = (mode_sel > 5) ? int'(mode_sel) - 4 : int'(mode_sel);
      end else if (m_armed && m_g1 && !m_g2 && retrig_mode) begin
        m_d = 0;
      end else if (m_armed && tick_en && (!gated_mode || m_g1)) begin
        m_d = m_d + 1;
      end
      m_g2 = m_g1;
      m_g1 = gate;
    end
  end

  function automatic void expect_now(output logic [15:0] ec, output logic eo);
    longint p;
    if (!m_armed) begin ec = 0; eo = 0; return; end
    p = m_d % m_n;
    case (m_mode)
      0, 1: begin ec = 16'((m_n - m_d) & 64'hFFFF); eo = (m_d >= m_n); end
      2:    begin ec = 16'((m_n - p) & 64'hFFFF); eo = (m_d != 0) && (p == 0); end
      3:    begin ec = 16'((m_n - ((2*p) % m_n)) & 64'hFFFF); eo = (p < (m_n + 1) / 2); end
      default: begin ec = 16'((m_n - m_d) & 64'hFFFF); eo = (m_d == m_n); end
    endcase
  endfunction

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      logic [15:0] ec; logic eo;
      expect_now(ec, eo);
      compared++;
      if (count_out !== ec || out_pin !== eo) begin
        mismatched++;
        $display("FAIL %s t=%0t count=%h out=%b expected count=%h out=%b",
                 cur_req, $time, count_out, out_pin, ec, eo);
      end
    end
  end

  task automatic do_load(input int md, input int val);
    @(negedge clk);
    load = 1; mode_sel = 3'(md); load_val = 16'(val);
    @(negedge clk);
    load = 0;
  endtask

  task automatic ticks(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = ((i % every) == 0);
    end
    @(negedge clk);
    tick_en = 0;
  endtask

  task automatic set_gate(input bit v);
    @(negedge clk);
    gate = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog expired (%s) actual=running expected=finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R1"; ticks(6, 1); set_gate(0); set_gate(1); ticks(4, 1);
    cur_req = "R3"; do_load(0, 5); ticks(12, 1);
    cur_req = "R9"; do_load(0, 4); ticks(20, 3);
    cur_req = "R8"; do_load(0, 6); ticks(3, 1); set_gate(0); ticks(5, 1); set_gate(1); ticks(8, 1);
    cur_req = "R4"; do_load(1, 6); ticks(4, 1); set_gate(0); set_gate(1); ticks(10, 1);
    set_gate(0); ticks(3, 1); set_gate(1); ticks(8, 1);
    cur_req = "R5"; do_load(2, 4); ticks(14, 1); set_gate(0); ticks(3, 1); set_gate(1); ticks(6, 1);
    cur_req = "R6"; do_load(3, 5); ticks(16, 1);
    do_load(3, 6); ticks(14, 1);
    do_load(3, 7); ticks(10, 1); set_gate(0); set_gate(1); ticks(9, 1);
    do_load(3, 1); ticks(4, 1);
    do_load(3, 2); ticks(6, 1);
    cur_req = "R7"; do_load(4, 3); ticks(10, 1);
    set_gate(0); ticks(4, 1); set_gate(1); ticks(3, 1);
    do_load(5, 4); ticks(7, 1); set_gate(0); set_gate(1); ticks(8, 1);
    cur_req = "R11"; do_load(6, 3); ticks(8, 1); do_load(7, 5); ticks(12, 1);
    cur_req = "R10"; do_load(1, 3); ticks(12, 1);
    cur_req = "R2"; do_load(0, 0); ticks(65540, 1);
    do_load(2, 0); ticks(40, 1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule